// File: doc/BRIEF.md
# All-One-Polynomial Bit-Serial Field Multiplier

This block multiplies two elements of GF(2^M) for fields whose defining polynomial is the all-one polynomial 1 + x + ... + x^M. Both operands and the result are held in an extended basis of M+1 coefficients. In that basis, reduction modulo x^(M+1)+1 is only a cyclic rotation, so the block needs no modulus input and no feedback taps.

A start strobe captures both operands and clears the product register. The block then runs M+1 iterations, one per clock. In each iteration one bit of the multiplier operand selects whether the current multiplicand is XORed into the product, and the multiplicand is rotated left by one place. The lowest multiplier bit is used first. A one-cycle done pulse marks the final product, and that value stays on the output until the next accepted start. The product in the extended basis can be folded to the ordinary M-bit polynomial basis by XORing its top coefficient into every lower coefficient.

Top module: `aop_gf_mul`

## Requirements
- R1: After reset, `prod` is all zeros and `done` and `busy` are both low.
- R2: A `start` sampled while `busy` is low loads the operands. From the next cycle `busy` is high and `prod` reads all zeros.
- R3: The final product satisfies prod[k] = XOR of a_in[i] & b_in[j] over every pair (i, j) with (i + j) mod (M+1) = k.
- R4: `done` is high for exactly one cycle, in the (M+1)th cycle after the edge that accepted `start`. `busy` is low in that same cycle.
- R5: After `done`, `prod` keeps its value until another `start` is accepted.
- R6: A `start` raised while `busy` is high is ignored. The running product and its completion time do not change.
- R7: When a_in[M] and b_in[M] are both zero, folding the product gives a*b reduced modulo 1+x+...+x^M. Folding means bit j of the folded value is prod[j] ^ prod[M] for j < M.
- R8: Coefficient M of the multiplicand wraps into coefficient 0. A product of x^M by x gives prod equal to 1 (only bit 0 set).
- R9: A `start` raised in the cycle where `done` is high is accepted, and a new operation begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin a multiplication; accepted only while idle |
| a_in | input | M+1 | Multiplicand, extended basis, bit k is coefficient of x^k |
| b_in | input | M+1 | Multiplier, extended basis, bit k is coefficient of x^k |
| prod | output | M+1 | Product in the extended basis |
| done | output | 1 | One-cycle pulse when the product is final |
| busy | output | 1 | High while iterations are running |

## Verification
A fault in the rotating multiplicand or in the multiplier shift register cannot stay hidden. Each iteration XORs the wrong word into the product, so the product differs from the cyclic convolution when `done` rises, M+1 cycles after the start. A miscounted iteration counter moves the done pulse off its cycle or lengthens it, and the bench sees this on the first operation. Corruption of the held product is visible in the cycle right after `done`. Single-bit operands placed at the top coefficient expose a broken wrap-around path on that same first result.

// File: rtl/aop_pkg.sv
package aop_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } aop_seq_e;
endpackage

// File: rtl/aop_rst_sync.sv
module aop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/aop_seq.sv
module aop_seq
  import aop_pkg::*;
#(
  parameter int M = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int W  = M + 1;
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  aop_seq_e       st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d;
  logic           last;

  assign load = start && (st_q == SEQ_IDLE);
  assign step = (st_q == SEQ_RUN);
  assign last = step && (cnt_q == LAST);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = last;
    if (load) begin
      st_d  = SEQ_RUN;
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (last) st_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = step;
  assign done = done_q;
endmodule

// File: rtl/aop_rotator.sv
module aop_rotator #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [M:0]   a_in,
  input  logic [M:0]   b_in,
  output logic [M:0]   mcand,
  output logic         sel_bit
);
  localparam int W = M + 1;

  logic [M:0] mc_q, mc_d, mc_rot;
  logic [M:0] bs_q, bs_d;
  logic       en;

  for (genvar g = 0; g < W; g++) begin : g_rot
    assign mc_rot[g] = mc_q[(g + W - 1) % W];
  end

  assign en = load || step;

  always_comb begin
    mc_d = mc_q;
    bs_d = bs_q;
    if (load) begin
      mc_d = a_in;
      bs_d = b_in;
    end else if (step) begin
      mc_d = mc_rot;
      bs_d = {1'b0, bs_q[M:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
      bs_q <= '0;
    end else if (en) begin
      mc_q <= mc_d;
      bs_q <= bs_d;
    end
  end

  assign mcand   = mc_q;
  assign sel_bit = bs_q[0];
endmodule

// File: rtl/aop_accum.sv
module aop_accum #(
  parameter int M = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic       sel_bit,
  input  logic [M:0] mcand,
  output logic [M:0] acc
);
  logic [M:0] acc_q, acc_d;
  logic       en;

  assign en = load || (step && sel_bit);

  always_comb begin
    acc_d = acc_q;
    if (load)                 acc_d = '0;
    else if (step && sel_bit) acc_d = acc_q ^ mcand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/aop_gf_mul.sv
module aop_gf_mul #(
  parameter int M = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [M:0] a_in,
  input  logic [M:0] b_in,
  output logic [M:0] prod,
  output logic       done,
  output logic       busy
);
  logic       rst_n_s;
  logic       load, step, sel_bit;
  logic [M:0] mcand;

  aop_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  aop_seq #(.M(M)) u_seq (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  aop_rotator #(.M(M)) u_rot (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (load),
    .step    (step),
    .a_in    (a_in),
    .b_in    (b_in),
    .mcand   (mcand),
    .sel_bit (sel_bit)
  );

  aop_accum #(.M(M)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (load),
    .step    (step),
    .sel_bit (sel_bit),
    .mcand   (mcand),
    .acc     (prod)
  );
endmodule

// File: rtl/aop_gf_mul_chk.sv
module aop_gf_mul_chk #(
  parameter int M = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [M:0] prod,
  input logic [M:0] mcand
);
  localparam int W  = M + 1;
  localparam int KW = $clog2(W + 2) + 1;

  logic [KW-1:0] since_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_load <= '0;
    else if (start && !busy) since_load <= '0;
    else if (busy)           since_load <= since_load + 1'b1;
  end

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_load == KW'(W)));

  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && (prod == '0)));

  // R5
  hold_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(prod));

  // R8
  rot_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(mcand) == $countones($past(mcand))));
endmodule

bind aop_gf_mul aop_gf_mul_chk #(.M(M)) u_chk (
  .clk   (clk),
  .rst_n (rst_n_s),
  .start (start),
  .busy  (busy),
  .done  (done),
  .prod  (prod),
  .mcand (mcand)
);

// File: tb/tb_aop_gf_mul.sv
module tb_aop_gf_mul;
  localparam int M = 4;
  localparam int W = M + 1;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] prod;
  logic         done, busy;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  aop_gf_mul #(.M(M)) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a_in  (a_in),
    .b_in  (b_in),
    .prod  (prod),
    .done  (done),
    .busy  (busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [W-1:0] cyc_conv(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (a[i] && b[j]) r[(i + j) % W] ^= 1'b1;
    return r;
  endfunction

  function automatic logic [M-1:0] aop_mod(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M:0] full = '0;
    for (int i = 0; i < M; i++)
      if (a[i]) full ^= (2*M+1)'(b) << i;
    for (int d = 2*M; d >= M; d--)
      if (full[d]) full ^= {{M{1'b0}}, {W{1'b1}}} << (d - M);
    return full[M-1:0];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Called just after a negedge; returns at the negedge where done is high.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic inject, output logic [W-1:0] res);
    a_in  = a;
    b_in  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", W'(busy), W'(1));
    check("R2 cleared", prod, '0);
    for (int k = 1; k < W; k++) begin
      if (inject && k == 2) begin
        a_in  = ~a;
        b_in  = ~b;
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      check("R4 early done", W'(done), W'(0));
    end
    @(negedge clk);
    check("R4 done", W'(done), W'(1));
    check("R4 busy low", W'(busy), W'(0));
    res = prod;
  endtask

  task automatic t_reset;
    check("R1 prod", prod, '0);
    check("R1 done", W'(done), W'(0));
    check("R1 busy", W'(busy), W'(0));
  endtask

  task automatic t_conv(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    run_op(a, b, 1'b0, r);
    check("R3 product", r, cyc_conv(a, b));
    @(negedge clk);
    check("R4 done drop", W'(done), W'(0));
    check("R5 hold", prod, r);
    repeat (3) @(negedge clk);
    check("R5 hold later", prod, r);
  endtask

  task automatic t_fold(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [W-1:0] r;
    logic [M-1:0] f;
    run_op({1'b0, a}, {1'b0, b}, 1'b0, r);
    f = r[M-1:0] ^ {M{r[M]}};
    check("R7 folded", W'(f), W'(aop_mod(a, b)));
    @(negedge clk);
  endtask

  task automatic t_wrap;
    logic [W-1:0] r;
    run_op(W'(1) << M, W'(2), 1'b0, r);
    check("R8 wrap", r, W'(1));
    @(negedge clk);
  endtask

  task automatic t_ignore;
    logic [W-1:0] r;
    run_op(5'b10110, 5'b01011, 1'b1, r);
    check("R6 ignored start", r, cyc_conv(5'b10110, 5'b01011));
    @(negedge clk);
  endtask

  task automatic t_chain;
    logic [W-1:0] r1, r2;
    run_op(5'b00111, 5'b11001, 1'b0, r1);
    check("R9 first", r1, cyc_conv(5'b00111, 5'b11001));
    run_op(5'b11010, 5'b10101, 1'b0, r2);
    check("R9 chained", r2, cyc_conv(5'b11010, 5'b10101));
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    a_in  = '0;
    b_in  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_conv(5'b01101, 5'b00001);
    t_conv(5'b00000, 5'b10111);
    t_conv(5'b11111, 5'b11111);
    t_conv(5'b10011, 5'b01110);
    t_wrap();
    t_ignore();
    t_chain();
    for (int n = 0; n < 30; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      t_conv(ra, rb);
    end
    for (int n = 0; n < 20; n++) begin
      logic [M-1:0] fa, fb;
      fa = M'($urandom);
      fb = M'($urandom);
      t_fold(fa, fb);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule